// File: doc/BRIEF.md
# Bus Controller Error Flag and Interrupt Aggregator

This block gathers the error events that a bus protocol engine reports and turns them into a small set of registers and one interrupt line. Eight event pulses (bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error) each set a sticky flag. The flags are gated by a per-flag enable register and ORed into one combined error status bit. That bit sits in an interrupt status register. An interrupt enable register gates it onto the interrupt output.

Each bus error also comes with a vector of detailed causes. These are stored in an error code register. The register either shows only the causes of the most recent error or, in accumulate mode, keeps collecting causes across errors. Flags and cause bits are cleared by writing zero to the bit; writing one leaves it alone. The transmit and receive error counters of the engine are inputs and can be read back as read-only registers.

Software reaches the registers through a simple single-cycle port: a write strobe with address and data, and a combinational read of the addressed register.

Top module: `err_agg_top`

## Requirements
- R1: After reset, every register (addresses 0 to 4) reads 0 and `irq_o` is low.
- R2: A one on `evt_i[k]` sets bit k of the flag register (address 1) at the next clock edge, and the bit stays set. Bit order: 7 bus lock, 6 overload frame, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning, 0 bus error.
- R3: A write to the flag register clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R4: If an event and a zero-write to the same flag occur in the same cycle, the flag ends up set.
- R5: Bit 5 of the interrupt status register (address 4) is 1 exactly when some flag is set and its bit in the flag enable register (address 0, same bit order, read/write) is 1. It stays 1 until every enabled flag is cleared. The other status bits read 0, and writes to address 4 are ignored.
- R6: `irq_o` is the OR over all bits of the interrupt status register ANDed with the interrupt enable register (address 3, read/write).
- R7: With bit 7 of the error code register (address 2) at 0, a pulse on `cause_vld_i` replaces bits 6:0 with `cause_i`. The previous causes are dropped. Cause bit order: 6 ACK delimiter, 5 bit error dominant, 4 bit error recessive, 3 CRC, 2 ACK, 1 form, 0 stuff.
- R8: With bit 7 of the error code register at 1 (accumulate mode), a pulse on `cause_vld_i` ORs `cause_i` into bits 6:0.
- R9: A write to the error code register stores bit 7 as written. For bits 6:0, a 0 in the data clears the bit and a 1 leaves it unchanged.
- R10: Address 5 reads `tx_cnt_i` and address 6 reads `rx_cnt_i`. Writes to these addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Error event pulses from the protocol engine |
| cause_vld_i | input | 1 | Strobe: a bus error occurred with the causes on cause_i |
| cause_i | input | NUM_CAUSE | Bus error cause vector |
| tx_cnt_i | input | CNT_W | Transmit error counter |
| rx_cnt_i | input | CNT_W | Receive error counter |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Register write data |
| rdata_o | output | DW | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The flags are driven with a sparse mixed pattern (0xA5). This shows that each event lands on its own bit. Selective zero-writes and an all-ones write separate a clear from a hold. An event that coincides with a clear-all write shows that the set has priority. The status tests raise a disabled flag, then an enabled one, then remove them one at a time. This separates the enable gating from the "held until all enabled flags clear" rule. Two back-to-back bus errors with disjoint cause vectors are applied in each cause mode. This tells replacement apart from accumulation.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
  localparam int ADDR_FLAG_EN = 0;
  localparam int ADDR_FLAGS   = 1;
  localparam int ADDR_CODE    = 2;
  localparam int ADDR_INT_EN  = 3;
  localparam int ADDR_INT_STS = 4;
  localparam int ADDR_TX_CNT  = 5;
  localparam int ADDR_RX_CNT  = 6;
  localparam int ERR_STS_BIT  = 5;
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_data_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] en_o,
  output logic         any_o
);
  logic [W-1:0] flags_q, en_q;

  for (genvar k = 0; k < W; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flags_q[k] <= 1'b0;
      else if (set_i[k])     flags_q[k] <= 1'b1;  // set beats clear
      else if (clr_wr_i && !clr_data_i[k]) flags_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_data_i;
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign any_o   = |(flags_q & en_q);

  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
  a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));
  a_r3_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((flags_q & ~$past(clr_data_i) & ~$past(set_i)) == '0));
  a_r3_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr_i |=> ((~flags_q & $past(flags_q)) == '0));
endmodule

// File: rtl/err_cause_store.sv
module err_cause_store #(
  parameter int NCAUSE = 7,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [NCAUSE-1:0] cause_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     code_o
);
  localparam int MODE_BIT = DW - 1;

  logic              mode_q;
  logic [NCAUSE-1:0] code_q, code_kept;

  always_comb begin
    code_kept = code_q;
    if (wr_i) code_kept = code_q & wdata_i[NCAUSE-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (wr_i) mode_q <= wdata_i[MODE_BIT];
      if (vld_i) code_q <= mode_q ? (code_kept | cause_i) : cause_i;
      else       code_q <= code_kept;
    end
  end

  always_comb begin
    code_o = '0;
    code_o[NCAUSE-1:0] = code_q;
    code_o[MODE_BIT]   = mode_q;
  end

  a_r7_latest_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !mode_q) |=> (code_q == $past(cause_i)));
  a_r8_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && mode_q) |=> ((code_q & $past(cause_i)) == $past(cause_i)));
  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !wr_i) |=> ($stable(code_q) && $stable(mode_q)));
endmodule

// File: rtl/err_irq_combine.sv
module err_irq_combine #(
  parameter int DW      = 8,
  parameter int STS_BIT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          err_sts_i,
  input  logic          ier_wr_i,
  input  logic [DW-1:0] ier_data_i,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] isr_o,
  output logic          irq_o
);
  logic [DW-1:0] ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ier_q <= '0;
    else if (ier_wr_i) ier_q <= ier_data_i;
  end

  always_comb begin
    isr_o = '0;
    isr_o[STS_BIT] = err_sts_i;
  end

  assign ier_o = ier_q;
  assign irq_o = |(isr_o & ier_q);

  a_r6_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> err_sts_i);
endmodule

// File: rtl/err_agg_top.sv
module err_agg_top
  import err_agg_pkg::*;
#(
  parameter int NUM_EVT   = 8,
  parameter int NUM_CAUSE = 7,
  parameter int CNT_W     = 8,
  parameter int DW        = 8,
  parameter int AW        = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic                 cause_vld_i,
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic [CNT_W-1:0]     tx_cnt_i,
  input  logic [CNT_W-1:0]     rx_cnt_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 irq_o
);
  logic [NUM_EVT-1:0] flags, flag_en;
  logic [DW-1:0]      code, ier, isr;
  logic               err_sts;
  logic               wr_en_reg, wr_flags, wr_code, wr_ier;

  assign wr_en_reg = wr_en_i && (addr_i == AW'(ADDR_FLAG_EN));
  assign wr_flags  = wr_en_i && (addr_i == AW'(ADDR_FLAGS));
  assign wr_code   = wr_en_i && (addr_i == AW'(ADDR_CODE));
  assign wr_ier    = wr_en_i && (addr_i == AW'(ADDR_INT_EN));

  err_flag_bank #(.W(NUM_EVT)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (evt_i),
    .clr_wr_i   (wr_flags),
    .clr_data_i (wdata_i[NUM_EVT-1:0]),
    .en_wr_i    (wr_en_reg),
    .en_data_i  (wdata_i[NUM_EVT-1:0]),
    .flags_o    (flags),
    .en_o       (flag_en),
    .any_o      (err_sts)
  );

  err_cause_store #(.NCAUSE(NUM_CAUSE), .DW(DW)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (cause_vld_i),
    .cause_i (cause_i),
    .wr_i    (wr_code),
    .wdata_i (wdata_i),
    .code_o  (code)
  );

  err_irq_combine #(.DW(DW), .STS_BIT(ERR_STS_BIT)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_sts_i  (err_sts),
    .ier_wr_i   (wr_ier),
    .ier_data_i (wdata_i),
    .ier_o      (ier),
    .isr_o      (isr),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      ADDR_FLAG_EN: rdata_o[NUM_EVT-1:0] = flag_en;
      ADDR_FLAGS:   rdata_o[NUM_EVT-1:0] = flags;
      ADDR_CODE:    rdata_o = code;
      ADDR_INT_EN:  rdata_o = ier;
      ADDR_INT_STS: rdata_o = isr;
      ADDR_TX_CNT:  rdata_o[CNT_W-1:0] = tx_cnt_i;
      ADDR_RX_CNT:  rdata_o[CNT_W-1:0] = rx_cnt_i;
      default:      rdata_o = '0;
    endcase
  end

  a_r5_sts_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr[ERR_STS_BIT] |-> ((flags & flag_en) != '0));
  a_r5_flag_reaches_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags & flag_en) != '0) |-> isr[ERR_STS_BIT]);
endmodule

// File: tb/err_agg_top_tb_top.sv
module err_agg_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] evt_i = '0;
  logic       cause_vld_i = 1'b0;
  logic [6:0] cause_i = '0;
  logic [7:0] tx_cnt_i = '0, rx_cnt_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  err_agg_top dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(req, rdata_o, exp);
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic pulse_cause(input logic [6:0] c);
    @(negedge clk_i);
    cause_vld_i = 1'b1; cause_i = c;
    @(negedge clk_i);
    cause_vld_i = 1'b0; cause_i = '0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) rd_chk("R1 reg", 3'(a), 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_flags;
    pulse_evt(8'hA5);
    rd_chk("R2 set", 3'd1, 8'hA5);
    repeat (3) @(negedge clk_i);
    rd_chk("R2 sticky", 3'd1, 8'hA5);
    wr(3'd1, 8'hFB);
    rd_chk("R3 clear bit2", 3'd1, 8'hA1);
    wr(3'd1, 8'hFF);
    rd_chk("R3 ones hold", 3'd1, 8'hA1);
    // event and clear-all in the same cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h00; evt_i = 8'h01;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0;
    rd_chk("R4 set wins", 3'd1, 8'h01);
  endtask

  task automatic t_status;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h02);
    rd_chk("R5 enable readback", 3'd0, 8'h02);
    pulse_evt(8'h01);
    rd_chk("R5 disabled flag", 3'd4, 8'h00);
    pulse_evt(8'h02);
    rd_chk("R5 enabled flag", 3'd4, 8'h20);
    chk("R6 irq gated off", {7'b0, irq_o}, 8'h00);
    wr(3'd3, 8'h20);
    #1 chk("R6 irq on", {7'b0, irq_o}, 8'h01);
    wr(3'd3, 8'hDF);
    #1 chk("R6 other enables", {7'b0, irq_o}, 8'h00);
    wr(3'd3, 8'h20);
    wr(3'd4, 8'h00);
    rd_chk("R5 status write ignored", 3'd4, 8'h20);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'hFD);
    rd_chk("R5 held by other flag", 3'd4, 8'h20);
    wr(3'd1, 8'hFE);
    rd_chk("R5 all cleared", 3'd4, 8'h00);
    #1 chk("R6 irq drops", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_causes;
    pulse_cause(7'h09);
    rd_chk("R7 first", 3'd2, 8'h09);
    pulse_cause(7'h12);
    rd_chk("R7 replaced", 3'd2, 8'h12);
    wr(3'd2, 8'h80);
    rd_chk("R9 mode set, causes cleared", 3'd2, 8'h80);
    pulse_cause(7'h05);
    pulse_cause(7'h40);
    rd_chk("R8 accumulate", 3'd2, 8'hC5);
    wr(3'd2, 8'hFB);
    rd_chk("R9 zero clears", 3'd2, 8'hC1);
    wr(3'd2, 8'h00);
    rd_chk("R9 all cleared", 3'd2, 8'h00);
  endtask

  task automatic t_counters;
    tx_cnt_i = 8'h3C; rx_cnt_i = 8'h7F;
    rd_chk("R10 tx", 3'd5, 8'h3C);
    rd_chk("R10 rx", 3'd6, 8'h7F);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h00);
    rd_chk("R10 tx after write", 3'd5, 8'h3C);
    rd_chk("R10 rx after write", 3'd6, 8'h7F);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_flags();
        t_status();
        t_causes();
        t_counters();
      end
      begin
        repeat (5000) @(negedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule